// File: doc/BRIEF.md
# Ethernet MAC Enable and Interrupt Control

This block is the control register file of a small Ethernet MAC. It holds the global run bit, a pending-event register with its enable mask, two descriptor-ready flags (one for receive, one for transmit) and two configuration words. Software reaches it through a plain synchronous register port with an address, a write strobe, write data and registered read data.

The block treats two kinds of reset differently. A hardware reset (`rst`) clears every register and output. Clearing the run bit through software is a soft reset: it resets only the datapath. The descriptor-ready flags drop, and the transmit, receive, DMA and descriptor engines each receive a one-cycle stop pulse. If a frame is on the wire at that moment, the transmitter is told to end it with a corrupted CRC. The configuration words, the event register and the mask all keep their values.

A combined interrupt line is raised one cycle after any unmasked event is pending. The engines themselves are outside this block. They appear only as the `tx_busy` and `hw_evt` inputs and as the control outputs.

Top module: `emac_ctrl_regs`

## Requirements
- R1: After a hardware reset all outputs are 0 and every register reads back as 0.
- R2: Bit 0 of the word at address 0 is the run bit. `mac_en` shows the written value from the cycle after the write.
- R3: When a write changes the run bit from 1 to 0 while `tx_busy` is high, `tx_abort` (abort and append a bad CRC) is high for exactly one cycle, and this is the same cycle in which `mac_en` falls. If `tx_busy` is low at that moment, `tx_abort` stays low.
- R4: On every 1-to-0 change of the run bit, `rx_abort`, `dma_stop` and `desc_halt` each pulse for exactly one cycle, in the cycle where `mac_en` falls. Writing 0 while the run bit is already 0 produces no pulse.
- R5: A write of any data to address 3 sets the receive descriptor-ready flag, and a write to address 4 sets the transmit flag, but only while the run bit is 1. While the run bit is 0 these writes are ignored. Both flags are forced to 0 when the run bit is cleared. Each flag reads back in bit 0 of its own address.
- R6: The configuration words at address 5 (transmit) and address 6 (receive) are read/write, and they keep their values when the run bit is cleared.
- R7: The event register at address 1 is write-one-to-clear. A `hw_evt` bit that is high in a cycle sets the matching event bit. Writing all ones clears every pending event.
- R8: If a `hw_evt` bit is high in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R9: `irq` equals the OR of (event AND mask) as they stood one cycle earlier. The mask is read/write at address 2.
- R10: Reads of addresses other than 0 to 6 return 0, and writes to them change no register.
- R11: `reg_rdata` is registered. It returns the value the addressed register held before the clock edge on which the address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| hw_evt | input | EVT_W | Event set pulses from the engines |
| tx_busy | input | 1 | Transmitter is sending a frame |
| mac_en | output | 1 | Run bit; datapath is held in reset while low |
| tx_abort | output | 1 | Pulse: abort the frame with a bad CRC |
| rx_abort | output | 1 | Pulse: abort receive activity |
| dma_stop | output | 1 | Pulse: terminate DMA activity |
| desc_halt | output | 1 | Pulse: halt the descriptor controller |
| rx_desc_active | output | 1 | Receive descriptor-ready flag |
| tx_desc_active | output | 1 | Transmit descriptor-ready flag |
| irq | output | 1 | Registered combined interrupt |

## Verification
A corrupted run bit or a wrong falling-edge detect shows up at the ports in the very next cycle, either as a missing or extra stop pulse or as a descriptor flag that stays up while `mac_en` is low. A corrupted event or mask bit shows up on `irq` one cycle later, and on `reg_rdata` one cycle after the address is presented. A bench model advanced on every edge and compared on every cycle therefore catches any divergence within two cycles of its cause. Directed sequences force the cases random traffic rarely reaches: a set and a clear of the same event bit in one cycle, a disable during a transmission, and descriptor writes while the block is stopped.

// File: rtl/emac_ctrl_pkg.sv
package emac_ctrl_pkg;
  // Register word offsets
  localparam int A_CTRL  = 0;
  localparam int A_EVT   = 1;
  localparam int A_MASK  = 2;
  localparam int A_RXACT = 3;
  localparam int A_TXACT = 4;
  localparam int A_TXCFG = 5;
  localparam int A_RXCFG = 6;

  // Stop strobes sent to the datapath engines
  typedef struct packed {
    logic tx_abort;
    logic rx_abort;
    logic dma_stop;
    logic desc_halt;
  } stop_t;
endpackage

// File: rtl/emac_enable_seq.sv
module emac_enable_seq
  import emac_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ctrl_we,
  input  logic  ctrl_bit,
  input  logic  tx_busy,
  output logic  en_q,
  output logic  en_next,
  output stop_t stop_q
);
  logic fall;

  always_comb begin
    en_next = ctrl_we ? ctrl_bit : en_q;
    fall    = en_q & ~en_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      stop_q <= '0;
    end else begin
      en_q             <= en_next;
      stop_q.tx_abort  <= fall & tx_busy;
      stop_q.rx_abort  <= fall;
      stop_q.dma_stop  <= fall;
      stop_q.desc_halt <= fall;
    end
  end
endmodule

// File: rtl/emac_desc_flag.sv
module emac_desc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_we,
  input  logic en_q,
  input  logic en_next,
  output logic act_q
);
  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= en_next & (act_q | (set_we & en_q));
  end
endmodule

// File: rtl/emac_irq_unit.sv
module emac_irq_unit #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] hw_evt,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_wdata,
  output logic [EVT_W-1:0] evt_q,
  output logic [EVT_W-1:0] mask_q,
  output logic             irq_q
);
  logic [EVT_W-1:0] clr_eff;

  always_comb clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~clr_eff) | hw_evt;
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= |(evt_q & mask_q);
    end
  end
endmodule

// File: rtl/emac_ctrl_regs.sv
module emac_ctrl_regs
  import emac_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  hw_evt,
  input  logic              tx_busy,
  output logic              mac_en,
  output logic              tx_abort,
  output logic              rx_abort,
  output logic              dma_stop,
  output logic              desc_halt,
  output logic              rx_desc_active,
  output logic              tx_desc_active,
  output logic              irq
);
  localparam int NUM_Q = 2;

  logic              en_next;
  stop_t             stop_q;
  logic [EVT_W-1:0]  evt_q;
  logic [EVT_W-1:0]  mask_q;
  logic [NUM_Q-1:0]  act_q;
  logic [CFG_W-1:0]  txcfg_q, rxcfg_q;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  function automatic logic hit(input int a);
    return reg_we && (reg_addr == ADDR_W'(a));
  endfunction

  assign unused_wdata = ^reg_wdata;

  emac_enable_seq u_en (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (hit(A_CTRL)),
    .ctrl_bit (reg_wdata[0]),
    .tx_busy  (tx_busy),
    .en_q     (mac_en),
    .en_next  (en_next),
    .stop_q   (stop_q)
  );

  emac_irq_unit #(.EVT_W(EVT_W)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .hw_evt     (hw_evt),
    .clr_we     (hit(A_EVT)),
    .clr_bits   (reg_wdata[EVT_W-1:0]),
    .mask_we    (hit(A_MASK)),
    .mask_wdata (reg_wdata[EVT_W-1:0]),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .irq_q      (irq)
  );

  // One descriptor-ready flag per direction: index 0 receive, 1 transmit
  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_desc
    localparam int ADDR_I = (gi == 0) ? A_RXACT : A_TXACT;
    emac_desc_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_we  (hit(ADDR_I)),
      .en_q    (mac_en),
      .en_next (en_next),
      .act_q   (act_q[gi])
    );
  end

  assign rx_desc_active = act_q[0];
  assign tx_desc_active = act_q[1];
  assign tx_abort       = stop_q.tx_abort;
  assign rx_abort       = stop_q.rx_abort;
  assign dma_stop       = stop_q.dma_stop;
  assign desc_halt      = stop_q.desc_halt;

  // Configuration words survive the soft reset
  always_ff @(posedge clk) begin
    if (rst) begin
      txcfg_q <= '0;
      rxcfg_q <= '0;
    end else begin
      if (hit(A_TXCFG)) txcfg_q <= reg_wdata[CFG_W-1:0];
      if (hit(A_RXCFG)) rxcfg_q <= reg_wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL):  rd_next = DATA_W'(mac_en);
      ADDR_W'(A_EVT):   rd_next = DATA_W'(evt_q);
      ADDR_W'(A_MASK):  rd_next = DATA_W'(mask_q);
      ADDR_W'(A_RXACT): rd_next = DATA_W'(act_q[0]);
      ADDR_W'(A_TXACT): rd_next = DATA_W'(act_q[1]);
      ADDR_W'(A_TXCFG): rd_next = DATA_W'(txcfg_q);
      ADDR_W'(A_RXCFG): rd_next = DATA_W'(rxcfg_q);
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/emac_ctrl_chk.sv
module emac_ctrl_chk #(
  parameter int EVT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mac_en,
  input logic             tx_abort,
  input logic             rx_abort,
  input logic             dma_stop,
  input logic             desc_halt,
  input logic             rx_desc_active,
  input logic             tx_desc_active,
  input logic             irq,
  input logic [EVT_W-1:0] hw_evt,
  input logic [EVT_W-1:0] evt_q,
  input logic [EVT_W-1:0] mask_q
);
  p_fall_stops_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mac_en) |-> (rx_abort && dma_stop && desc_halt));

  p_stop_single_r4: assert property (@(posedge clk) disable iff (rst)
    dma_stop |=> !dma_stop);

  p_stop_only_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    desc_halt |-> $fell(mac_en));

  p_txabort_with_stop_r3: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> (dma_stop && !mac_en));

  p_desc_off_r5: assert property (@(posedge clk) disable iff (rst)
    !mac_en |-> (!rx_desc_active && !tx_desc_active));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|(evt_q & mask_q)) |=> irq);

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(evt_q & mask_q)) |=> !irq);

  p_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    hw_evt[0] |=> evt_q[0]);
endmodule

bind emac_ctrl_regs emac_ctrl_chk #(.EVT_W(EVT_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .mac_en         (mac_en),
  .tx_abort       (tx_abort),
  .rx_abort       (rx_abort),
  .dma_stop       (dma_stop),
  .desc_halt      (desc_halt),
  .rx_desc_active (rx_desc_active),
  .tx_desc_active (tx_desc_active),
  .irq            (irq),
  .hw_evt         (hw_evt),
  .evt_q          (evt_q),
  .mask_q         (mask_q)
);

// File: tb/emac_ctrl_regs_tb.sv
module emac_ctrl_regs_tb_top;
  localparam int AW = 4, DW = 32, EW = 16, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [EW-1:0] hw_evt = '0;
  logic tx_busy = 1'b0;
  logic mac_en, tx_abort, rx_abort, dma_stop, desc_halt;
  logic rx_desc_active, tx_desc_active, irq;

  int tests = 0;
  int fails = 0;
  bit started = 0;

  always #2 clk = ~clk;  // 250 MHz

  emac_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW), .EVT_W(EW), .CFG_W(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_evt(hw_evt),
    .tx_busy(tx_busy), .mac_en(mac_en), .tx_abort(tx_abort),
    .rx_abort(rx_abort), .dma_stop(dma_stop), .desc_halt(desc_halt),
    .rx_desc_active(rx_desc_active), .tx_desc_active(tx_desc_active),
    .irq(irq)
  );

  // Behavioural reference, built from the requirements
  bit m_en, m_rx, m_tx, m_irq, m_txab, m_stop;
  int unsigned m_evt, m_mask, m_txc, m_rxc, m_rd;

  function automatic int unsigned model_read(int a);
    case (a)
      0: return m_en;
      1: return m_evt;
      2: return m_mask;
      3: return m_rx;
      4: return m_tx;
      5: return m_txc;
      6: return m_rxc;
      default: return 0;  // R10
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_en = 0; m_rx = 0; m_tx = 0; m_irq = 0; m_txab = 0; m_stop = 0;
      m_evt = 0; m_mask = 0; m_txc = 0; m_rxc = 0; m_rd = 0;
    end else begin
      int a;
      bit new_en, was_en;
      a = int'(reg_addr);
      m_rd  = model_read(a);                 // R11: pre-edge value
      m_irq = (m_evt & m_mask) != 0;         // R9
      was_en = m_en;
      new_en = (reg_we && a == 0) ? reg_wdata[0] : m_en;
      m_stop = was_en && !new_en;            // R4
      m_txab = m_stop && tx_busy;            // R3
      m_rx = new_en && (m_rx || (reg_we && a == 3 && was_en));  // R5
      m_tx = new_en && (m_tx || (reg_we && a == 4 && was_en));
      if (reg_we && a == 1) m_evt = m_evt & ~(reg_wdata & 32'hFFFF);  // R7
      m_evt = m_evt | hw_evt;                // R8: set wins
      if (reg_we && a == 2) m_mask = reg_wdata & 32'hFFFF;
      if (reg_we && a == 5) m_txc = reg_wdata & 32'hFFFF;    // R6
      if (reg_we && a == 6) m_rxc = reg_wdata & 32'hFFFF;
      m_en = new_en;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R2 mac_en", mac_en, m_en);
      check("R3 tx_abort", tx_abort, m_txab);
      check("R4 rx_abort", rx_abort, m_stop);
      check("R4 dma_stop", dma_stop, m_stop);
      check("R4 desc_halt", desc_halt, m_stop);
      check("R5 rx_desc_active", rx_desc_active, m_rx);
      check("R5 tx_desc_active", tx_desc_active, m_tx);
      check("R9 irq", irq, m_irq);
      check("R11 reg_rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, longint exp, string tag);
    @(negedge clk);
    reg_addr = AW'(a); reg_we = 1'b0;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse_evt(logic [EW-1:0] v);
    @(negedge clk);
    hw_evt = v;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 mac_en", mac_en, 0);
    for (int a = 0; a < 16; a++) rd(a, 0, "R1 reset read");

    // R7 / R9: events, mask, write-one-to-clear
    wr(2, 32'h0005);
    pulse_evt(16'h0004);
    rd(1, 32'h4, "R7 event set");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 0, "R7 all-ones clear");
    pulse_evt(16'h0003);
    wr(1, 32'h1);
    rd(1, 32'h2, "R7 single clear");
    // R8: set and clear of the same bit in one cycle
    @(negedge clk);
    reg_addr = 4'd1; reg_we = 1'b1; reg_wdata = 32'h3; hw_evt = 16'h0002;
    @(negedge clk);
    reg_we = 1'b0; hw_evt = '0;
    rd(1, 32'h2, "R8 set wins");
    wr(1, 32'hFFFF_FFFF);

    // R5: descriptor writes ignored while stopped
    wr(3, 0);
    wr(4, 0);
    rd(3, 0, "R5 rx ignored");
    rd(4, 0, "R5 tx ignored");
    wr(0, 1);
    rd(0, 1, "R2 run bit");
    wr(3, 0);
    wr(4, 0);
    rd(3, 1, "R5 rx set");
    rd(4, 1, "R5 tx set");
    wr(5, 32'hABCD);
    wr(6, 32'h1234);

    // R3 / R4: disable during a transmission
    tx_busy = 1'b1;
    wr(0, 0);
    tx_busy = 1'b0;
    rd(4, 0, "R5 cleared on stop");
    rd(5, 32'hABCD, "R6 txcfg kept");
    rd(6, 32'h1234, "R6 rxcfg kept");
    rd(2, 32'h5, "R6 mask kept");
    // R4: writing 0 when already stopped gives no pulse (per-cycle compare)
    wr(0, 0);
    // disable without a frame in flight: no bad-CRC request
    wr(0, 1);
    wr(0, 0);

    // R10: unmapped addresses
    wr(9, 32'hFFFF_FFFF);
    wr(15, 32'h1);
    rd(9, 0, "R10 unmapped read");
    rd(2, 32'h5, "R10 mask untouched");
    rd(0, 0, "R10 run bit untouched");

    // Random traffic, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_addr  = AW'(($urandom % 10 == 0) ? 12 : ($urandom % 7));
      reg_we    = ($urandom % 3) == 0;
      reg_wdata = $urandom;
      hw_evt    = (($urandom % 4) == 0) ? EW'($urandom) : '0;
      tx_busy   = $urandom % 2;
    end
    @(negedge clk);
    reg_we = 1'b0; hw_evt = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule